// File: doc/BRIEF.md
# Coarse and Fine Offset Accumulator

This block holds the two digital codes that drive a pair of offset DACs: a fine code that moves in small signed steps and a coarse code that absorbs carries from it. Each valid cycle brings a signed step, either a single count or a larger multi-count step. The block adds it to the fine code. If the result stays within the fine range, the fine code takes the new value.

If the step pushes the fine code past its top or below zero, the fine code does not wrap and it does not saturate. It snaps back to midscale and the coarse code moves by one in the same direction. The coarse code saturates at both ends. Once the coarse code is pinned at an end, a further carry in that direction clamps the fine code at its own limit instead of re-centring it.

A load port writes both codes directly, for example to restore a stored calibration. The synchronous active-low reset puts both codes at midscale.

Top module: `offset_accum`

## Requirements
- R1: While rst_n is low at a rising clock edge, the following outputs are coarse_code = 32 and fine_code = 128, which are the midscale values for the default widths (6-bit coarse, 8-bit fine).
- R2: With step_valid low and load_en low, neither coarse_code nor fine_code changes, whatever step_amt holds.
- R3: On a valid cycle whose two's-complement step_amt keeps fine_code + step_amt within 0..255, fine_code becomes that sum and coarse_code is unchanged.
- R4: On a valid cycle where fine_code + step_amt exceeds 255 and coarse_code is below 63, fine_code becomes 128 and coarse_code increases by one. This holds for single-count and multi-count steps.
- R5: On a valid cycle where fine_code + step_amt is below 0 and coarse_code is above 0, fine_code becomes 128 and coarse_code decreases by one. This holds for single-count and multi-count steps.
- R6: An overflow while coarse_code is 63 leaves coarse_code at 63 and sets fine_code to 255.
- R7: An underflow while coarse_code is 0 leaves coarse_code at 0 and sets fine_code to 0.
- R8: When load_en is high, the next codes are load_coarse and load_fine, and any step presented in the same cycle is ignored.
- R9: A sum of exactly 255 or exactly 0 is in range. It is stored as is, with no carry.
- R10: Both codes change together on the first rising edge after the valid or load cycle, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Qualifies step_amt for this cycle |
| step_amt | input | STEP_W (8) | Signed two's-complement fine adjustment |
| load_en | input | 1 | Direct load of both codes, overrides the step |
| load_coarse | input | COARSE_W (6) | Coarse value to load |
| load_fine | input | FINE_W (8) | Fine value to load |
| coarse_code | output | COARSE_W (6) | Coarse DAC code |
| fine_code | output | FINE_W (8) | Fine DAC code |

## Verification
Every result of this block, whether from a step, a load or a reset, is due exactly one rising edge after the cycle that presents it, because each path passes through the single register stage holding the two codes. The bench changes inputs on the falling edge and samples one time unit after the next rising edge, so each check sees the result of exactly one stimulus. For R10, the outputs are also read shortly before that edge, which confirms the old value still holds. The vector table is a chain: each expected pair follows from the previous vector's result, so a wrong carry or a wrong re-centre shows up in every later entry.

// File: rtl/offset_accum_pkg.sv
// Shared types for the offset accumulator.
// Assumes: nothing beyond SystemVerilog packages.
package offset_accum_pkg;

    // Classification of the fine sum against the fine range
    typedef enum logic [1:0] {
        FINE_IN_RANGE = 2'd0,
        FINE_OVER     = 2'd1,
        FINE_UNDER    = 2'd2
    } fine_class_t;

endpackage

// File: rtl/offset_fine_sum.sv
// Adds a signed step to the unsigned fine code in a sum two bits wider
// than the wider operand, then classifies the result as in range, over
// the top or below zero.
// Assumes: the fine code is unsigned, and the step is two's complement.
module offset_fine_sum
    import offset_accum_pkg::*;
#(
    parameter int FINE_W = 8,
    parameter int STEP_W = 8
) (
    input  logic [FINE_W-1:0] fine_in,
    input  logic [STEP_W-1:0] step_in,
    output logic [FINE_W-1:0] sum_trunc,
    output fine_class_t       sum_class
);
    localparam int SUM_W = ((FINE_W > STEP_W) ? FINE_W : STEP_W) + 2;
    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << FINE_W) - 1);

    logic signed [SUM_W-1:0] fine_ext;
    logic signed [SUM_W-1:0] step_ext;
    logic signed [SUM_W-1:0] sum_wide;

    // Widen both operands, add, and classify the signed result
    always_comb begin
        fine_ext  = $signed({{(SUM_W-FINE_W){1'b0}}, fine_in});
        step_ext  = $signed({{(SUM_W-STEP_W){step_in[STEP_W-1]}}, step_in});
        sum_wide  = fine_ext + step_ext;
        sum_trunc = sum_wide[FINE_W-1:0];
        if (sum_wide[SUM_W-1]) begin
            sum_class = FINE_UNDER;
        end else if (sum_wide > TOP) begin
            sum_class = FINE_OVER;
        end else begin
            sum_class = FINE_IN_RANGE;
        end
    end
endmodule

// File: rtl/offset_coarse_carry.sv
// Moves the coarse code by one on a fine overflow or underflow, and
// saturates at both ends. Reports whether the carry was taken, so the
// fine path knows to re-centre rather than clamp.
// Assumes: an in-range class never moves the coarse code.
module offset_coarse_carry
    import offset_accum_pkg::*;
#(
    parameter int COARSE_W = 6
) (
    input  logic [COARSE_W-1:0] coarse_in,
    input  fine_class_t         sum_class,
    output logic [COARSE_W-1:0] coarse_next,
    output logic                carry_taken
);
    localparam logic [COARSE_W-1:0] C_TOP = '1;
    localparam logic [COARSE_W-1:0] C_BOT = '0;
    localparam logic [COARSE_W-1:0] C_ONE = COARSE_W'(1);

    // Apply the carry unless the coarse code is pinned in that direction
    always_comb begin
        coarse_next = coarse_in;
        carry_taken = 1'b0;
        unique case (sum_class)
            FINE_OVER: begin
                if (coarse_in != C_TOP) begin
                    coarse_next = coarse_in + C_ONE;
                    carry_taken = 1'b1;
                end
            end
            FINE_UNDER: begin
                if (coarse_in != C_BOT) begin
                    coarse_next = coarse_in - C_ONE;
                    carry_taken = 1'b1;
                end
            end
            default: begin
                coarse_next = coarse_in;
                carry_taken = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/offset_fine_select.sv
// Picks the next fine code: the sum when in range, midscale after a
// carry, or the limit on the side of the overflow when the coarse code
// is saturated.
// Assumes: carry_taken is only set for an out-of-range class.
module offset_fine_select
    import offset_accum_pkg::*;
#(
    parameter int FINE_W = 8
) (
    input  logic [FINE_W-1:0] sum_trunc,
    input  fine_class_t       sum_class,
    input  logic              carry_taken,
    output logic [FINE_W-1:0] fine_next
);
    localparam logic [FINE_W-1:0] F_MID = FINE_W'(1 << (FINE_W - 1));
    localparam logic [FINE_W-1:0] F_TOP = '1;
    localparam logic [FINE_W-1:0] F_BOT = '0;

    // Choose between sum, re-centre and clamp
    always_comb begin
        if (sum_class == FINE_IN_RANGE) begin
            fine_next = sum_trunc;
        end else if (carry_taken) begin
            fine_next = F_MID;
        end else if (sum_class == FINE_OVER) begin
            fine_next = F_TOP;
        end else begin
            fine_next = F_BOT;
        end
    end
endmodule

// File: rtl/offset_accum.sv
// Coarse and fine offset accumulator. Holds the coarse and fine DAC
// codes in one register stage. On a valid step, it adds the step to the
// fine code. A fine overflow or underflow re-centres the fine code and
// carries one into the coarse code. Load overrides the step, and reset
// overrides both.
// Assumes: synchronous active-low reset, and one clock domain.
module offset_accum
    import offset_accum_pkg::*;
#(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 6,
    parameter int STEP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_valid,
    input  logic [STEP_W-1:0]   step_amt,
    input  logic                load_en,
    input  logic [COARSE_W-1:0] load_coarse,
    input  logic [FINE_W-1:0]   load_fine,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code
);
    localparam logic [FINE_W-1:0]   F_MID = FINE_W'(1 << (FINE_W - 1));
    localparam logic [COARSE_W-1:0] C_MID = COARSE_W'(1 << (COARSE_W - 1));

    logic [FINE_W-1:0]   sum_trunc;
    fine_class_t         sum_class;
    logic [COARSE_W-1:0] coarse_next;
    logic                carry_taken;
    logic [FINE_W-1:0]   fine_next;

    offset_fine_sum #(
        .FINE_W (FINE_W),
        .STEP_W (STEP_W)
    ) u_sum (
        .fine_in   (fine_code),
        .step_in   (step_amt),
        .sum_trunc (sum_trunc),
        .sum_class (sum_class)
    );

    offset_coarse_carry #(
        .COARSE_W (COARSE_W)
    ) u_carry (
        .coarse_in   (coarse_code),
        .sum_class   (sum_class),
        .coarse_next (coarse_next),
        .carry_taken (carry_taken)
    );

    offset_fine_select #(
        .FINE_W (FINE_W)
    ) u_select (
        .sum_trunc   (sum_trunc),
        .sum_class   (sum_class),
        .carry_taken (carry_taken),
        .fine_next   (fine_next)
    );

    // Register both codes together: reset, then load, then a valid step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_code <= C_MID;
            fine_code   <= F_MID;
        end else if (load_en) begin
            coarse_code <= load_coarse;
            fine_code   <= load_fine;
        end else if (step_valid) begin
            coarse_code <= coarse_next;
            fine_code   <= fine_next;
        end
    end
endmodule

// File: rtl/offset_accum_chk.sv
// Property checker for offset_accum, attached with bind. It recomputes
// the fine sum on its own, in plain integer arithmetic.
// Assumes: it sees the top-level ports only.
module offset_accum_chk #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 6,
    parameter int STEP_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_valid,
    input logic [STEP_W-1:0]   step_amt,
    input logic                load_en,
    input logic [COARSE_W-1:0] load_coarse,
    input logic [FINE_W-1:0]   load_fine,
    input logic [COARSE_W-1:0] coarse_code,
    input logic [FINE_W-1:0]   fine_code
);
    localparam int F_TOP = (1 << FINE_W) - 1;
    localparam int F_MID = 1 << (FINE_W - 1);
    localparam int C_TOP = (1 << COARSE_W) - 1;
    localparam int C_MID = 1 << (COARSE_W - 1);

    int chk_sum;
    int c_now;
    int f_now;

    // Independent integer view of the sum and of the codes
    always_comb begin
        chk_sum = int'(fine_code) + int'($signed(step_amt));
        c_now   = int'(coarse_code);
        f_now   = int'(fine_code);
    end

    AST_RESET_MID: assert property (@(posedge clk)
        !rst_n |=> (c_now == C_MID) && (f_now == F_MID)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_valid && !load_en) |=> $stable(coarse_code) && $stable(fine_code)); // R2

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !load_en && chk_sum >= 0 && chk_sum <= F_TOP)
        |=> (f_now == $past(chk_sum)) && $stable(coarse_code)); // R3

    AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !load_en && chk_sum > F_TOP && c_now != C_TOP)
        |=> (f_now == F_MID) && (c_now == $past(c_now) + 1)); // R4

    AST_CARRY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !load_en && chk_sum < 0 && c_now != 0)
        |=> (f_now == F_MID) && (c_now == $past(c_now) - 1)); // R5

    AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !load_en && chk_sum > F_TOP && c_now == C_TOP)
        |=> (f_now == F_TOP) && (c_now == C_TOP)); // R6

    AST_BOTTOM_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !load_en && chk_sum < 0 && c_now == 0)
        |=> (f_now == 0) && (c_now == 0)); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (coarse_code == $past(load_coarse)) && (fine_code == $past(load_fine))); // R8

    AST_COARSE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (c_now == $past(c_now)) || (f_now == F_MID)
                     || (f_now == 0) || (f_now == F_TOP) || (c_now == $past(c_now) + 1)
                     || (c_now == $past(c_now) - 1)); // R10
endmodule

bind offset_accum offset_accum_chk #(
    .FINE_W   (FINE_W),
    .COARSE_W (COARSE_W),
    .STEP_W   (STEP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .step_amt    (step_amt),
    .load_en     (load_en),
    .load_coarse (load_coarse),
    .load_fine   (load_fine),
    .coarse_code (coarse_code),
    .fine_code   (fine_code)
);

// File: tb/offset_accum_test.sv
// Self-checking bench for offset_accum: a chained vector table, then
// directed tests for load, saturation, latency and reset.
module offset_accum_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [3:0] rq;
        logic       vld;
        logic [7:0] step;
        logic [5:0] ec;
        logic [7:0] ef;
    } vec_t;

    // Chained from the reset state (32,128); each entry follows the last
    localparam vec_t VECS [NVEC] = '{
        '{4'd3, 1'b1, 8'h05, 6'd32, 8'd133},  // R3 +5
        '{4'd2, 1'b0, 8'h64, 6'd32, 8'd133},  // R2 invalid step ignored
        '{4'd3, 1'b1, 8'hFD, 6'd32, 8'd130},  // R3 -3
        '{4'd9, 1'b1, 8'h7D, 6'd32, 8'd255},  // R9 sum exactly 255
        '{4'd4, 1'b1, 8'h01, 6'd33, 8'd128},  // R4 single-count overflow
        '{4'd9, 1'b1, 8'h80, 6'd33, 8'd0},    // R9 sum exactly 0
        '{4'd5, 1'b1, 8'hFF, 6'd32, 8'd128},  // R5 single-count underflow
        '{4'd3, 1'b1, 8'h7F, 6'd32, 8'd255},  // R3 +127
        '{4'd4, 1'b1, 8'h7F, 6'd33, 8'd128},  // R4 multi-count overflow
        '{4'd3, 1'b1, 8'h80, 6'd33, 8'd0},    // R3 -128
        '{4'd5, 1'b1, 8'h80, 6'd32, 8'd128},  // R5 multi-count underflow
        '{4'd2, 1'b0, 8'hFF, 6'd32, 8'd128}   // R2 invalid step ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_valid = 1'b0;
    logic [7:0] step_amt = '0;
    logic       load_en = 1'b0;
    logic [5:0] load_coarse = '0;
    logic [7:0] load_fine = '0;
    logic [5:0] coarse_code;
    logic [7:0] fine_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    offset_accum uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_valid  (step_valid),
        .step_amt    (step_amt),
        .load_en     (load_en),
        .load_coarse (load_coarse),
        .load_fine   (load_fine),
        .coarse_code (coarse_code),
        .fine_code   (fine_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, int act_c, int act_f, int exp_c, int exp_f);
        checks = checks + 1;
        if (act_c != exp_c || act_f != exp_f) begin
            failures = failures + 1;
            $display("FAIL %s: actual coarse=%0d fine=%0d expected coarse=%0d fine=%0d",
                     req, act_c, act_f, exp_c, exp_f);
        end
    endtask

    // One stimulus cycle: drive at the falling edge, sample after the rising edge
    task automatic apply(logic v, logic [7:0] s, logic ld, logic [5:0] lc, logic [7:0] lf);
        @(negedge clk);
        step_valid  = v;
        step_amt    = s;
        load_en     = ld;
        load_coarse = lc;
        load_fine   = lf;
        @(posedge clk);
        #1;
        @(negedge clk);
        step_valid = 1'b0;
        load_en    = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", coarse_code, fine_code, 32, 128);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].vld, VECS[i].step, 1'b0, 6'd0, 8'd0);
            check($sformatf("R%0d table vector %0d", VECS[i].rq, i),
                  coarse_code, fine_code, VECS[i].ec, VECS[i].ef);
        end

        // R8: load wins over a valid step in the same cycle
        @(negedge clk);
        step_valid = 1'b1; step_amt = 8'h03;
        load_en = 1'b1; load_coarse = 6'd63; load_fine = 8'd250;
        @(posedge clk); #1;
        check("R8 load priority", coarse_code, fine_code, 63, 250);
        @(negedge clk);
        step_valid = 1'b0; load_en = 1'b0;

        // R6: overflow at coarse top clamps fine at 255
        apply(1'b1, 8'h0A, 1'b0, 6'd0, 8'd0);
        check("R6 top clamp", coarse_code, fine_code, 63, 255);
        apply(1'b1, 8'h01, 1'b0, 6'd0, 8'd0);
        check("R6 top clamp repeat", coarse_code, fine_code, 63, 255);

        // R7: underflow at coarse bottom clamps fine at 0
        apply(1'b0, 8'h00, 1'b1, 6'd0, 8'd5);
        check("R8 load bottom", coarse_code, fine_code, 0, 5);
        apply(1'b1, 8'hFA, 1'b0, 6'd0, 8'd0);
        check("R7 bottom clamp", coarse_code, fine_code, 0, 0);

        // R10: no change before the edge, both codes move at the edge
        apply(1'b0, 8'h00, 1'b1, 6'd10, 8'd254);
        @(negedge clk);
        step_valid = 1'b1; step_amt = 8'h05;
        #(CLK_PERIOD/2 - 1);
        check("R10 before edge", coarse_code, fine_code, 10, 254);
        @(posedge clk); #1;
        check("R10 after edge", coarse_code, fine_code, 11, 128);
        @(negedge clk);
        step_valid = 1'b0;

        // R1: reset mid-run overrides a valid step
        @(negedge clk);
        rst_n = 1'b0; step_valid = 1'b1; step_amt = 8'h20;
        @(posedge clk); #1;
        check("R1 reset mid-run", coarse_code, fine_code, 32, 128);
        @(negedge clk);
        rst_n = 1'b1; step_valid = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule